// File: doc/BRIEF.md
# Store-to-Load Overlap Detector

This block watches the memory operations placed in one dispatch group and flags any load that may read bytes written by the last store in that group. Each access names its address as two operands. An operand is either a register tag or a signed constant offset, and a flag says which one it is. When the store-capture strobe is high, the block records the store's two operands and its access size. The recorded store is replaced by the next store and is dropped when the group-clear strobe arrives.

For each load-check request, the load's operands are compared with the recorded store's operands in the same order and in swapped order. When the two second operands match and both first operands are constants, the block also checks whether the two byte ranges overlap. A scheduler inserts a no-op when the registered flag goes high one cycle after the request.

Top module: `store_load_alias_detect`

## Requirements
- R1: After reset, `hit_o` is low and no store is recorded, so a load issued before any store capture never raises `hit_o`.
- R2: The 2-bit access-kind code sets the access size in bytes for stores and loads alike: 2'b00 = 1 (byte), 2'b01 = 2 (halfword), 2'b10 = 4 (word or single float), 2'b11 = 8 (double float).
- R3: A load whose first and second operands equal the recorded store's first and second operands flags a hit.
- R4: A load whose first operand equals the store's second operand, and whose second operand equals the store's first operand, flags a hit.
- R5: Two operands are equal only when both are constants with the same 16-bit value, or when both are registers with the same tag. A constant never equals a register. The tag of a constant and the value of a register are ignored.
- R6: When the second operands match and both first operands are constants, let S and L be the store and load offsets. If S < L, a hit is flagged when S + store size > L. Otherwise a hit is flagged when L + load size > S.
- R7: With no recorded store, no hit is flagged. `grp_clr_i` without `st_cap_i` discards the recorded store from the next cycle on.
- R8: A store capture replaces the recorded operands and size. After the replacement, only the new store can cause hits.
- R9: `hit_o` is registered. It reflects the load request sampled at the previous clock edge and is low in any cycle that follows a cycle without a request.
- R10: A load checked in the same cycle as a store capture or a group clear is compared with the store recorded before that edge. When `st_cap_i` and `grp_clr_i` are both high, the new store is kept.
- R11: Offset sums are formed without wraparound, so a store at 32764 of size 8 overlaps a byte load at 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_clr_i | input | 1 | Dispatch group boundary; drops the recorded store |
| st_cap_i | input | 1 | Record the store operands and size |
| st_a_const_i | input | 1 | Store first operand is a constant |
| st_a_tag_i | input | TAG_W | Store first operand register tag |
| st_a_val_i | input | OFS_W | Store first operand constant value (signed) |
| st_b_const_i | input | 1 | Store second operand is a constant |
| st_b_tag_i | input | TAG_W | Store second operand register tag |
| st_b_val_i | input | OFS_W | Store second operand constant value (signed) |
| st_kind_i | input | 2 | Store access-kind code |
| ld_req_i | input | 1 | Load-check request |
| ld_a_const_i | input | 1 | Load first operand is a constant |
| ld_a_tag_i | input | TAG_W | Load first operand register tag |
| ld_a_val_i | input | OFS_W | Load first operand constant value (signed) |
| ld_b_const_i | input | 1 | Load second operand is a constant |
| ld_b_tag_i | input | TAG_W | Load second operand register tag |
| ld_b_val_i | input | OFS_W | Load second operand constant value (signed) |
| ld_kind_i | input | 2 | Load access-kind code |
| hit_o | output | 1 | Overlap flag for the load requested one cycle earlier |

## Verification
A store capture or group clear takes effect at the clock edge where its strobe is sampled, so it governs loads from the next cycle on. The overlap result for a load request sampled at one edge appears on `hit_o` just after that edge and holds for exactly that cycle. The bench drives every stimulus on the falling edge and clears the load request at the next falling edge. It reads `hit_o` at that same falling edge, which is half a cycle after the rising edge that registered the result. It then reads `hit_o` one cycle later to confirm that the flag has dropped. Same-edge cases are driven in a single cycle: a capture together with a clear, and a load together with a capture. This confirms that the load saw the old recorded state.

// File: rtl/sla_pkg.sv
package sla_pkg;
  typedef enum logic [1:0] {
    KIND_BYTE = 2'b00,
    KIND_HALF = 2'b01,
    KIND_WORD = 2'b10,
    KIND_DBL  = 2'b11
  } acc_kind_e;

  localparam int SIZE_W = 4;

  function automatic logic [SIZE_W-1:0] kind_bytes(input logic [1:0] k);
    return SIZE_W'(1) << k;
  endfunction
endpackage

// File: rtl/sla_opnd_eq.sv
module sla_opnd_eq #(
  parameter int TAG_W = 5,
  parameter int OFS_W = 16
) (
  input  logic             x_const_i,
  input  logic [TAG_W-1:0] x_tag_i,
  input  logic [OFS_W-1:0] x_val_i,
  input  logic             y_const_i,
  input  logic [TAG_W-1:0] y_tag_i,
  input  logic [OFS_W-1:0] y_val_i,
  output logic             eq_o
);
  always_comb begin
    if (x_const_i != y_const_i) eq_o = 1'b0;
    else if (x_const_i)         eq_o = (x_val_i == y_val_i);
    else                        eq_o = (x_tag_i == y_tag_i);
  end
endmodule

// File: rtl/sla_range_ovl.sv
module sla_range_ovl #(
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic signed [OFS_W-1:0] st_ofs_i,
  input  logic [SIZE_W-1:0]       st_size_i,
  input  logic signed [OFS_W-1:0] ld_ofs_i,
  input  logic [SIZE_W-1:0]       ld_size_i,
  output logic                    ovl_o
);
  localparam int SUM_W = (OFS_W > SIZE_W ? OFS_W : SIZE_W) + 2;

  logic signed [SUM_W-1:0] st_x, ld_x, st_end, ld_end;

  always_comb begin
    st_x   = SUM_W'(st_ofs_i);
    ld_x   = SUM_W'(ld_ofs_i);
    st_end = st_x + $signed({2'b00, SUM_W'(st_size_i)});
    ld_end = ld_x + $signed({2'b00, SUM_W'(ld_size_i)});
    if (st_x < ld_x) ovl_o = (st_end > ld_x);
    else             ovl_o = (ld_end > st_x);
  end
endmodule

// File: rtl/store_load_alias_detect.sv
module store_load_alias_detect
  import sla_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grp_clr_i,
  input  logic             st_cap_i,
  input  logic             st_a_const_i,
  input  logic [TAG_W-1:0] st_a_tag_i,
  input  logic [OFS_W-1:0] st_a_val_i,
  input  logic             st_b_const_i,
  input  logic [TAG_W-1:0] st_b_tag_i,
  input  logic [OFS_W-1:0] st_b_val_i,
  input  logic [1:0]       st_kind_i,
  input  logic             ld_req_i,
  input  logic             ld_a_const_i,
  input  logic [TAG_W-1:0] ld_a_tag_i,
  input  logic [OFS_W-1:0] ld_a_val_i,
  input  logic             ld_b_const_i,
  input  logic [TAG_W-1:0] ld_b_tag_i,
  input  logic [OFS_W-1:0] ld_b_val_i,
  input  logic [1:0]       ld_kind_i,
  output logic             hit_o
);
  localparam int NOPS = 2;

  // recorded store; rec_size == 0 means none
  logic             rec_c [NOPS];
  logic [TAG_W-1:0] rec_t [NOPS];
  logic [OFS_W-1:0] rec_v [NOPS];
  logic [SIZE_W-1:0] rec_size;

  logic             ld_c [NOPS];
  logic [TAG_W-1:0] ld_t [NOPS];
  logic [OFS_W-1:0] ld_v [NOPS];

  assign ld_c[0] = ld_a_const_i;  assign ld_c[1] = ld_b_const_i;
  assign ld_t[0] = ld_a_tag_i;    assign ld_t[1] = ld_b_tag_i;
  assign ld_v[0] = ld_a_val_i;    assign ld_v[1] = ld_b_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_size <= '0;
      for (int i = 0; i < NOPS; i++) begin
        rec_c[i] <= 1'b0;
        rec_t[i] <= '0;
        rec_v[i] <= '0;
      end
    end else if (st_cap_i) begin
      rec_size <= kind_bytes(st_kind_i);
      rec_c[0] <= st_a_const_i;  rec_c[1] <= st_b_const_i;
      rec_t[0] <= st_a_tag_i;    rec_t[1] <= st_b_tag_i;
      rec_v[0] <= st_a_val_i;    rec_v[1] <= st_b_val_i;
    end else if (grp_clr_i) begin
      rec_size <= '0;
    end
  end

  // pair_eq[i][j]: load operand i vs recorded operand j
  logic [NOPS-1:0] pair_eq [NOPS];

  for (genvar i = 0; i < NOPS; i++) begin : g_ld
    for (genvar j = 0; j < NOPS; j++) begin : g_st
      sla_opnd_eq #(.TAG_W(TAG_W), .OFS_W(OFS_W)) u_eq (
        .x_const_i(ld_c[i]), .x_tag_i(ld_t[i]), .x_val_i(ld_v[i]),
        .y_const_i(rec_c[j]), .y_tag_i(rec_t[j]), .y_val_i(rec_v[j]),
        .eq_o(pair_eq[i][j])
      );
    end
  end

  logic rng_ovl, same_hit, swap_hit, rng_hit, rec_live;

  sla_range_ovl #(.OFS_W(OFS_W), .SIZE_W(SIZE_W)) u_rng (
    .st_ofs_i (rec_v[0]),
    .st_size_i(rec_size),
    .ld_ofs_i (ld_v[0]),
    .ld_size_i(kind_bytes(ld_kind_i)),
    .ovl_o    (rng_ovl)
  );

  assign rec_live = (rec_size != '0);
  assign same_hit = pair_eq[0][0] & pair_eq[1][1];
  assign swap_hit = pair_eq[0][1] & pair_eq[1][0];
  assign rng_hit  = pair_eq[1][1] & ld_c[0] & rec_c[0] & rng_ovl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= ld_req_i & rec_live & (same_hit | swap_hit | rng_hit);
  end
endmodule

// File: rtl/sla_chk.sv
module sla_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic grp_clr_i,
  input logic st_cap_i,
  input logic ld_req_i,
  input logic hit_o,
  input logic rec_live,
  input logic same_hit,
  input logic swap_hit
);
  // R9
  hit_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(ld_req_i));

  // R9
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_req_i |=> !hit_o);

  // R7
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_i && $past(grp_clr_i && !st_cap_i)) |=> !hit_o);

  // R3
  same_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_i && rec_live && same_hit) |=> hit_o);

  // R4
  swapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_i && rec_live && swap_hit) |=> hit_o);

  // R8
  capture_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(st_cap_i) |-> rec_live);
endmodule

bind store_load_alias_detect sla_chk u_sla_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .grp_clr_i(grp_clr_i),
  .st_cap_i (st_cap_i),
  .ld_req_i (ld_req_i),
  .hit_o    (hit_o),
  .rec_live (rec_live),
  .same_hit (same_hit),
  .swap_hit (swap_hit)
);

// File: tb/store_load_alias_detect_bench.sv
module store_load_alias_detect_bench;
  localparam int TAG_W = 5;
  localparam int OFS_W = 16;
  localparam int OP_W  = 1 + TAG_W + OFS_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic grp_clr = 1'b0, st_cap = 1'b0, ld_req = 1'b0;
  logic [OP_W-1:0] st_a = '0, st_b = '0, ld_a = '0, ld_b = '0;
  logic [1:0] st_kind = '0, ld_kind = '0;
  logic hit;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  store_load_alias_detect u_store_load_alias_detect (
    .clk_i(clk), .rst_ni(rst_ni), .grp_clr_i(grp_clr), .st_cap_i(st_cap),
    .st_a_const_i(st_a[OP_W-1]), .st_a_tag_i(st_a[OFS_W +: TAG_W]), .st_a_val_i(st_a[OFS_W-1:0]),
    .st_b_const_i(st_b[OP_W-1]), .st_b_tag_i(st_b[OFS_W +: TAG_W]), .st_b_val_i(st_b[OFS_W-1:0]),
    .st_kind_i(st_kind), .ld_req_i(ld_req),
    .ld_a_const_i(ld_a[OP_W-1]), .ld_a_tag_i(ld_a[OFS_W +: TAG_W]), .ld_a_val_i(ld_a[OFS_W-1:0]),
    .ld_b_const_i(ld_b[OP_W-1]), .ld_b_tag_i(ld_b[OFS_W +: TAG_W]), .ld_b_val_i(ld_b[OFS_W-1:0]),
    .ld_kind_i(ld_kind), .hit_o(hit)
  );

  // register operand: value field junk to show it is ignored (R5)
  function automatic logic [OP_W-1:0] rg(input int t);
    return {1'b0, TAG_W'(t), 16'hA5A5};
  endfunction
  // constant operand: tag field junk
  function automatic logic [OP_W-1:0] cn(input int v);
    return {1'b1, TAG_W'(31), OFS_W'(v)};
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic store(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input logic [1:0] k);
    @(negedge clk);
    st_a = a; st_b = b; st_kind = k; st_cap = 1'b1;
    @(negedge clk);
    st_cap = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    grp_clr = 1'b1;
    @(negedge clk);
    grp_clr = 1'b0;
  endtask

  task automatic load(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input logic [1:0] k,
                      input logic exp, input string req);
    @(negedge clk);
    ld_a = a; ld_b = b; ld_kind = k; ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    chk(hit, exp, req);
  endtask

  task automatic t_reset();
    chk(hit, 1'b0, "R1 reset value");
    load(rg(0), rg(0), 2'b10, 1'b0, "R1 load before any store");
    load(cn(0), cn(0), 2'b00, 1'b0, "R7 no recorded store");
  endtask

  task automatic t_exact_swap();
    clear();
    store(cn(8), rg(3), 2'b10);
    load(cn(8), rg(3), 2'b10, 1'b1, "R3 same order");
    @(negedge clk); chk(hit, 1'b0, "R9 flag lasts one cycle");
    store(rg(4), rg(5), 2'b10);
    load(rg(4), rg(5), 2'b00, 1'b1, "R3 indexed same order");
    load(rg(5), rg(4), 2'b00, 1'b1, "R4 swapped order");
    load(rg(5), rg(6), 2'b00, 1'b0, "R4 partial swap no hit");
  endtask

  task automatic t_equality();
    clear();
    store(rg(4), rg(9), 2'b10);
    load(cn(4), rg(9), 2'b10, 1'b0, "R5 const vs reg differ");
    load({1'b0, TAG_W'(4), 16'h1234}, rg(9), 2'b10, 1'b1, "R5 reg value field ignored");
    store(cn(7), rg(9), 2'b00);
    load({1'b1, TAG_W'(2), OFS_W'(7)}, rg(9), 2'b00, 1'b1, "R5 const tag field ignored");
  endtask

  task automatic t_ranges();
    clear();
    store(cn(8), rg(3), 2'b10);
    load(cn(11), rg(3), 2'b00, 1'b1, "R6 store below, last byte");
    load(cn(12), rg(3), 2'b00, 1'b0, "R6 store below, just past");
    load(cn(4),  rg(3), 2'b10, 1'b0, "R6 load below, adjacent");
    load(cn(5),  rg(3), 2'b10, 1'b1, "R6 load below, overlap");
    load(cn(1),  rg(3), 2'b11, 1'b1, "R2 double load size 8");
    load(cn(0),  rg(3), 2'b11, 1'b0, "R2 double load ends at store");
    load(cn(9),  rg(7), 2'b00, 1'b0, "R6 other base register");
    store(cn(20), rg(3), 2'b00);
    load(cn(21), rg(3), 2'b00, 1'b0, "R2 byte store size 1");
    load(cn(19), rg(3), 2'b01, 1'b1, "R2 half load size 2");
    load(cn(19), rg(3), 2'b00, 1'b0, "R2 byte load size 1");
    store(cn(20), rg(3), 2'b01);
    load(cn(21), rg(3), 2'b00, 1'b1, "R2 half store size 2");
    store(cn(20), rg(3), 2'b11);
    load(cn(27), rg(3), 2'b00, 1'b1, "R2 double store size 8");
    load(cn(28), rg(3), 2'b00, 1'b0, "R2 double store end");
    store(cn(-4), rg(3), 2'b10);
    load(cn(-1), rg(3), 2'b00, 1'b1, "R6 negative offsets");
  endtask

  task automatic t_wrap();
    clear();
    store(cn(32764), rg(2), 2'b11);
    load(cn(32767), rg(2), 2'b00, 1'b1, "R11 no wrap store end");
    store(cn(-32768), rg(2), 2'b00);
    load(cn(32767), rg(2), 2'b11, 1'b0, "R11 far offsets");
  endtask

  task automatic t_clear_replace();
    store(cn(0), rg(1), 2'b10);
    clear();
    load(cn(0), rg(1), 2'b10, 1'b0, "R7 clear drops store");
    store(rg(10), rg(11), 2'b10);
    store(rg(12), rg(13), 2'b10);
    load(rg(10), rg(11), 2'b10, 1'b0, "R8 old store replaced");
    load(rg(12), rg(13), 2'b10, 1'b1, "R8 new store recorded");
  endtask

  task automatic t_same_edge();
    clear();
    @(negedge clk);
    st_a = rg(20); st_b = rg(21); st_kind = 2'b10; st_cap = 1'b1; grp_clr = 1'b1;
    @(negedge clk);
    st_cap = 1'b0; grp_clr = 1'b0;
    load(rg(20), rg(21), 2'b10, 1'b1, "R10 capture wins over clear");
    clear();
    @(negedge clk);
    st_a = rg(22); st_b = rg(23); st_cap = 1'b1;
    ld_a = rg(22); ld_b = rg(23); ld_req = 1'b1;
    @(negedge clk);
    st_cap = 1'b0; ld_req = 1'b0;
    chk(hit, 1'b0, "R10 load sees pre-capture state");
    @(negedge clk);
    grp_clr = 1'b1; ld_a = rg(22); ld_b = rg(23); ld_req = 1'b1;
    @(negedge clk);
    grp_clr = 1'b0; ld_req = 1'b0;
    chk(hit, 1'b1, "R10 load sees pre-clear state");
    load(rg(22), rg(23), 2'b10, 1'b0, "R7 cleared after same-edge load");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact_swap();
    t_equality();
    t_ranges();
    t_wrap();
    t_clear_replace();
    t_same_edge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule